// File: doc/BRIEF.md
# DMA Request Pacer with Work-Unit Deadline Monitor

This block sits next to one memory-to-memory DMA channel and does two separate jobs. The first job is pacing. It passes the channel's request line through to the bus only when enough clock cycles have gone by since the last request that was accepted. Two throttle values are special. Zero removes all pacing, so a request can go out on every cycle. All-ones holds back every request until software writes a different value.

The second job is a deadline watch. A down-counter is loaded with a cycle budget whenever the configuration is written, a work unit ends, or an autobuffer wraps. The counter then counts down on each cycle that a work unit is active. If the counter is decremented to zero before the unit is done, the block raises a sticky error flag and reports error code 6. The transfer itself continues. Software clears the flag with a write-one-to-clear strobe. A budget of zero turns the watch off.

Top module: `dma_pace_guard`

## Requirements
- R1: With throttle count N (0 < N < 0xFFFF), after a forwarded request is granted (`gatedReq` and `chanGrant` both high at a clock edge), `gatedReq` stays low for the next N cycles even though `chanReq` stays high. It rises again on cycle N+1.
- R2: With throttle count 0x0000, `gatedReq` equals `chanReq` on every cycle, including back-to-back granted cycles.
- R3: With throttle count 0xFFFF, `gatedReq` stays low whatever `chanReq` does. Once a different value is applied, requests pass again.
- R4: `gatedReq` is low whenever `chanReq` is low. A forwarded request that is not granted keeps `gatedReq` high and does not start the spacing interval.
- R5: A pulse on `cfgWrite`, `unitDone` or `wrapPulse` loads `monitorCount` into `monitorCur` at the next clock edge. In that same edge the load takes priority over a decrement.
- R6: `monitorCur` decrements by one at each edge where `unitActive` is high, no load is requested and the counter is not already zero. It does not change while `unitActive` is low.
- R7: When a decrement takes `monitorCur` from 1 to 0, `errFlag` is high after that edge and `errCode` reads 4'h6. `monitorCur` then holds at 0 until the next load. `errCode` reads 4'h0 while `errFlag` is low.
- R8: A deadline error does not stop the channel. `gatedReq` keeps following the pacing rules while `errFlag` is high.
- R9: A `monitorCount` of 0 that has been loaded leaves `monitorCur` at 0 and never raises `errFlag`, however long `unitActive` stays high.
- R10: `errFlag` stays set until `errClear` is pulsed, and clears at the edge after that pulse. If an expiry and `errClear` fall on the same edge, the flag ends up set.
- R11: While `rst_n` is low, `monitorCur` is 0, `errFlag` is 0, `errCode` is 0 and the spacing interval is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chanReq | input | 1 | Request from the DMA channel |
| chanGrant | input | 1 | Bus grant for the forwarded request |
| unitActive | input | 1 | High while a work unit is in progress |
| unitDone | input | 1 | One-cycle pulse when a work unit completes |
| wrapPulse | input | 1 | One-cycle pulse on autobuffer wrap |
| cfgWrite | input | 1 | One-cycle pulse on a configuration register write |
| errClear | input | 1 | Write-one-to-clear strobe for the error flag |
| throttleCount | input | 16 | Minimum number of idle cycles between forwarded requests |
| monitorCount | input | 32 | Cycle budget for a work unit; 0 turns the monitor off |
| gatedReq | output | 1 | Paced request sent to the bus |
| monitorCur | output | 32 | Current value of the deadline counter |
| errFlag | output | 1 | Sticky deadline error |
| errCode | output | 4 | Error code: 6 while `errFlag` is set, else 0 |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a completion and an expiry. The bench lets the counter reach 1 with the unit active and pulses `unitDone` in that same cycle. It then expects a reload to the full budget and no error. The second pair is a clear and a new expiry. The bench pulses `errClear` in the cycle where the counter goes from 1 to 0 and expects the flag to be set afterwards. A reload pulse during an active cycle is also checked, and the expected result is the reloaded value rather than a decremented one.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadSpace;
    logic reloadMon;
    logic decMon;
  } dpg_strobe_t;

  // counter status from datapath back to control
  typedef struct packed {
    logic spaceIdle;
    logic monIsZero;
    logic monIsOne;
  } dpg_status_t;
endpackage

// File: rtl/dpg_datapath.sv
module dpg_datapath
  import dpg_pkg::*;
#(
  parameter int THROTTLE_W = 16,
  parameter int MONITOR_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpg_strobe_t           strb,
  input  logic [THROTTLE_W-1:0] throttleCount,
  input  logic [MONITOR_W-1:0]  monitorCount,
  output dpg_status_t           stat,
  output logic [MONITOR_W-1:0]  monCur
);
  localparam logic [THROTTLE_W-1:0] SPACE_ZERO = '0;
  localparam logic [MONITOR_W-1:0]  MON_ZERO   = '0;
  localparam logic [MONITOR_W-1:0]  MON_ONE    = MON_ZERO + 1'b1;

  logic [THROTTLE_W-1:0] spaceCnt;

  // spacing counter: restarts on an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  spaceCnt <= SPACE_ZERO;
    else if (strb.loadSpace)     spaceCnt <= throttleCount;
    else if (spaceCnt != SPACE_ZERO) spaceCnt <= spaceCnt - 1'b1;
  end

  // deadline counter: load has priority over decrement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              monCur <= MON_ZERO;
    else if (strb.reloadMon) monCur <= monitorCount;
    else if (strb.decMon)    monCur <= monCur - 1'b1;
  end

  always_comb begin
    stat.spaceIdle = (spaceCnt == SPACE_ZERO);
    stat.monIsZero = (monCur == MON_ZERO);
    stat.monIsOne  = (monCur == MON_ONE);
  end

  a_r1_spacing_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadSpace && throttleCount != SPACE_ZERO) |=> !stat.spaceIdle);

  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reloadMon |=> (monCur == $past(monitorCount)));

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    strb.decMon |=> (monCur == $past(monCur) - 1'b1));

  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (monCur == MON_ZERO && !strb.reloadMon) |=> (monCur == MON_ZERO));
endmodule

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
  import dpg_pkg::*;
#(
  parameter int              THROTTLE_W = 16,
  parameter int              ERR_W      = 4,
  parameter logic [ERR_W-1:0] DEADLINE_CODE = 4'h6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chanReq,
  input  logic                  chanGrant,
  input  logic                  unitActive,
  input  logic                  unitDone,
  input  logic                  wrapPulse,
  input  logic                  cfgWrite,
  input  logic                  errClear,
  input  logic [THROTTLE_W-1:0] throttleCount,
  input  dpg_status_t           stat,
  output dpg_strobe_t           strb,
  output logic                  gatedReq,
  output logic                  errFlag,
  output logic [ERR_W-1:0]      errCode
);
  localparam logic [THROTTLE_W-1:0] STOP_ALL = '1;

  logic stopAll;
  logic expire;

  always_comb begin
    stopAll        = (throttleCount == STOP_ALL);
    gatedReq       = chanReq && stat.spaceIdle && !stopAll;
    strb.loadSpace = gatedReq && chanGrant;
    strb.reloadMon = cfgWrite || unitDone || wrapPulse;
    strb.decMon    = !strb.reloadMon && unitActive && !stat.monIsZero;
    expire         = strb.decMon && stat.monIsOne;
    errCode        = errFlag ? DEADLINE_CODE : '0;
  end

  // sticky flag, a new expiry beats the clear strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        errFlag <= 1'b0;
    else if (expire)   errFlag <= 1'b1;
    else if (errClear) errFlag <= 1'b0;
  end

  a_r7_expiry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.decMon && stat.monIsOne) |=> errFlag);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !errClear) |=> errFlag);

  a_r4_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!chanReq) |-> !strb.loadSpace);
endmodule

// File: rtl/dma_pace_guard.sv
module dma_pace_guard
  import dpg_pkg::*;
#(
  parameter int THROTTLE_W = 16,
  parameter int MONITOR_W  = 32,
  parameter int ERR_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chanReq,
  input  logic                  chanGrant,
  input  logic                  unitActive,
  input  logic                  unitDone,
  input  logic                  wrapPulse,
  input  logic                  cfgWrite,
  input  logic                  errClear,
  input  logic [THROTTLE_W-1:0] throttleCount,
  input  logic [MONITOR_W-1:0]  monitorCount,
  output logic                  gatedReq,
  output logic [MONITOR_W-1:0]  monitorCur,
  output logic                  errFlag,
  output logic [ERR_W-1:0]      errCode
);
  dpg_strobe_t strb;
  dpg_status_t stat;

  dpg_ctrl #(.THROTTLE_W(THROTTLE_W), .ERR_W(ERR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chanReq(chanReq), .chanGrant(chanGrant),
    .unitActive(unitActive), .unitDone(unitDone), .wrapPulse(wrapPulse),
    .cfgWrite(cfgWrite), .errClear(errClear), .throttleCount(throttleCount),
    .stat(stat), .strb(strb), .gatedReq(gatedReq), .errFlag(errFlag),
    .errCode(errCode)
  );

  dpg_datapath #(.THROTTLE_W(THROTTLE_W), .MONITOR_W(MONITOR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .throttleCount(throttleCount),
    .monitorCount(monitorCount), .stat(stat), .monCur(monitorCur)
  );
endmodule

// File: tb/dma_pace_guard_bench.sv
module dma_pace_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chanReq = 0, chanGrant = 0, unitActive = 0, unitDone = 0;
  logic wrapPulse = 0, cfgWrite = 0, errClear = 0;
  logic [15:0] throttleCount = '0;
  logic [31:0] monitorCount = '0;
  logic gatedReq, errFlag;
  logic [31:0] monitorCur;
  logic [3:0] errCode;

  always #4 clk = ~clk;  // 125 MHz

  dma_pace_guard u_dma_pace_guard (
    .clk(clk), .rst_n(rst_n), .chanReq(chanReq), .chanGrant(chanGrant),
    .unitActive(unitActive), .unitDone(unitDone), .wrapPulse(wrapPulse),
    .cfgWrite(cfgWrite), .errClear(errClear), .throttleCount(throttleCount),
    .monitorCount(monitorCount), .gatedReq(gatedReq), .monitorCur(monitorCur),
    .errFlag(errFlag), .errCode(errCode)
  );

  // 0 gatedReq, 1 monitorCur, 2 errFlag, 3 errCode
  typedef struct {
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_item_t;

  exp_item_t expQ[$];
  exp_item_t cur;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  task automatic expect_out(input int sel, input logic [31:0] val, input string tag);
    exp_item_t it;
    it.sel = sel; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: samples one ns before the rising edge
  initial forever begin
    @(negedge clk);
    #3;
    while (expQ.size() > 0) begin
      logic [31:0] act;
      cur = expQ.pop_front();
      case (cur.sel)
        0: act = {31'd0, gatedReq};
        1: act = monitorCur;
        2: act = {31'd0, errFlag};
        default: act = {28'd0, errCode};
      endcase
      checkCnt++;
      if (act !== cur.val) begin
        failCnt++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", cur.tag, cur.sel, act, cur.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    step();
    expect_out(1, 0, "R11"); expect_out(2, 0, "R11"); expect_out(3, 0, "R11");
    step(); rst_n = 1'b1;

    // R1 spacing of 3 cycles
    throttleCount = 16'd3; chanGrant = 1;
    step(); chanReq = 1; expect_out(0, 1, "R1");
    step(); expect_out(0, 0, "R1");
    step(); expect_out(0, 0, "R1");
    step(); expect_out(0, 0, "R1");
    step(); expect_out(0, 1, "R1");
    step(); chanReq = 0; expect_out(0, 0, "R4");
    for (int i = 0; i < 3; i++) step();
    // R4 ungranted request holds high, no spacing started
    step(); chanReq = 1; chanGrant = 0; expect_out(0, 1, "R4");
    step(); expect_out(0, 1, "R4");
    step(); expect_out(0, 1, "R4");
    step(); chanGrant = 1; expect_out(0, 1, "R4");
    step(); expect_out(0, 0, "R4");
    step(); chanReq = 0;
    for (int i = 0; i < 3; i++) step();

    // R2 unlimited
    step(); throttleCount = 16'h0000; chanReq = 1; expect_out(0, 1, "R2");
    step(); expect_out(0, 1, "R2");
    step(); expect_out(0, 1, "R2");
    step(); chanReq = 0; expect_out(0, 0, "R2");
    // R3 stop all
    step(); throttleCount = 16'hFFFF; chanReq = 1; expect_out(0, 0, "R3");
    step(); expect_out(0, 0, "R3");
    step(); expect_out(0, 0, "R3");
    step(); throttleCount = 16'h0000; expect_out(0, 1, "R3");

    // monitor: budget 5
    step(); monitorCount = 32'd5; cfgWrite = 1; expect_out(1, 0, "R5");
    step(); cfgWrite = 0; unitActive = 1; expect_out(1, 5, "R5");
    step(); expect_out(1, 4, "R6");
    step(); expect_out(1, 3, "R6");
    step(); expect_out(1, 2, "R6");
    step(); expect_out(1, 1, "R6"); expect_out(2, 0, "R7");
    step(); expect_out(1, 0, "R7"); expect_out(2, 1, "R7"); expect_out(3, 6, "R7");
    expect_out(0, 1, "R8");
    step(); expect_out(1, 0, "R7"); expect_out(0, 1, "R8");
    step(); unitDone = 1;
    step(); unitDone = 0; unitActive = 0; errClear = 1;
    expect_out(1, 5, "R5"); expect_out(2, 1, "R10");
    step(); errClear = 0; expect_out(2, 0, "R10"); expect_out(3, 0, "R7");
    expect_out(1, 5, "R6");
    step(); expect_out(1, 5, "R6");
    // wrap reload beats decrement
    unitActive = 1;
    step(); expect_out(1, 4, "R6");
    wrapPulse = 1; expect_out(1, 4, "R5");
    step(); wrapPulse = 0; expect_out(1, 5, "R5");
    // collision: done in the expiry cycle
    step(); expect_out(1, 4, "R6");
    step(); expect_out(1, 3, "R6");
    step(); expect_out(1, 2, "R6");
    step(); expect_out(1, 1, "R6"); unitDone = 1;
    step(); unitDone = 0; expect_out(1, 5, "R5"); expect_out(2, 0, "R7");
    // collision: clear in the expiry cycle
    step(); expect_out(1, 4, "R6");
    step(); step();
    step(); expect_out(1, 1, "R6"); errClear = 1;
    step(); errClear = 0; expect_out(2, 1, "R10"); expect_out(1, 0, "R7");

    // R9 disabled monitor
    step(); unitActive = 0; monitorCount = 32'd0; cfgWrite = 1; errClear = 1;
    step(); cfgWrite = 0; errClear = 0; unitActive = 1;
    expect_out(1, 0, "R9"); expect_out(2, 0, "R9");
    step(); step(); step();
    step(); expect_out(1, 0, "R9"); expect_out(2, 0, "R9"); expect_out(3, 0, "R9");
    step(); step();

    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule